// File: doc/BRIEF.md
# Write-Cycle Status Read Logic

This block drives the byte-wide read bus of a nonvolatile memory. When no programming period is running, a qualified read returns the array contents supplied by a neighbouring storage block. While the memory is programming internally, reads return a status word instead. This lets the host detect completion in either of two ways. The first is a complemented top bit when it reads the byte it wrote last. The second is a second-highest bit that alternates from one read to the next.

The block keeps a copy of the address and data of the most recent byte load, a one-bit toggle state, and a registered copy of the read qualifier. The qualifier marks the cycle in which a read ends. The block also drives the enable for an external tri-state buffer. The write sequencer sits outside this block. It reports each byte load, the start of each programming period, and the busy level. A write attempt that software protection rejects still gets a programming start and a busy period from the sequencer, so reads during that period poll in the same way.

Enables are active low and sampled on `clk_i`. The read path from the enables, address and busy level to the outputs is combinational.

Top module: `poll_status_read`

## Requirements
- R1: `data_oe_o` is high in the same cycle exactly when `ce_ni` is 0, `oe_ni` is 0 and `we_ni` is 1.
- R2: While `data_oe_o` is low, `data_o` is all zeros.
- R3: During a qualified read with `busy_i` low, `data_o` equals `arr_data_i`.
- R4: During a qualified read with `busy_i` high and `addr_i` equal to the last captured address, bit 7 of `data_o` is the inverse of bit 7 of the last captured data, and bits 5..0 equal the last captured data.
- R5: During a qualified read with `busy_i` high and any other address, bit 7 and bits 5..0 of `data_o` come from `arr_data_i`.
- R6: During a qualified read with `busy_i` high, bit 6 of `data_o` shows the toggle state, at any address. The toggle state inverts at the first clock edge at which a read that was qualified at the previous edge is no longer qualified, provided `busy_i` is high.
- R7: `prog_start_i` clears the toggle state to 0 at the next edge. This takes priority over a read ending in the same cycle.
- R8: While `busy_i` is low and `prog_start_i` is low, the toggle state holds. A qualified read then returns true bit 6.
- R9: A cycle with `wr_strobe_i` high captures `wr_addr_i` and `wr_data_i` as the last written byte. Polling depends only on `busy_i`, so a protection-blocked write that still starts a programming period is polled normally.
- R10: After reset, the last captured address and data are 0 and the toggle state is 0. A busy read of address 0 then returns 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Read address |
| arr_data_i | input | DATA_W | Array data at `addr_i` from the storage block |
| busy_i | input | 1 | Internal programming period in progress |
| prog_start_i | input | 1 | One-cycle pulse at the start of a programming period |
| wr_strobe_i | input | 1 | Byte load accepted by the write sequencer |
| wr_addr_i | input | ADDR_W | Address of the loaded byte |
| wr_data_i | input | DATA_W | Data of the loaded byte |
| data_o | output | DATA_W | Read data or status word |
| data_oe_o | output | 1 | Tri-state buffer enable for the data bus |

## Verification
Two events can meet in the same cycle: a read ending, which inverts the toggle, and the start of a new programming period, which clears it. The bench first sets the toggle state to 0. It then releases output enable in the very cycle that `prog_start_i` pulses. The next poll read must show bit 6 as 0, where an inversion would have shown 1. A second case is busy dropping in the middle of a read. There the bench expects true data in the same cycle and no further bit 6 change. A behavioural model compares every cycle across a long stretch of mixed random traffic.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    RD_OFF  = 2'd0,
    RD_TRUE = 2'd1,
    RD_POLL = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/psr_bus_ctl.sv
module psr_bus_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic rd_act_o,
  output logic rd_end_o
);
  logic rd_q;

  assign rd_act_o = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_act_o;
  end

  // read completes when the qualifier drops
  assign rd_end_o = rd_q & ~rd_act_o;

  assert_end_after_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_end_o |-> ($past(rd_act_o) && !rd_act_o));
endmodule

// File: rtl/psr_wr_capture.sv
module psr_wr_capture #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_strobe_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] last_addr_o,
  output logic [DATA_W-1:0] last_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_o <= '0;
      last_data_o <= '0;
    end else if (wr_strobe_i) begin
      last_addr_o <= wr_addr_i;
      last_data_o <= wr_data_i;
    end
  end

  assert_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_i |=> (last_addr_o == $past(wr_addr_i) && last_data_o == $past(wr_data_i)));
  assert_capture_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_strobe_i |=> ($stable(last_addr_o) && $stable(last_data_o)));
endmodule

// File: rtl/psr_toggle.sv
module psr_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic prog_start_i,
  input  logic rd_end_i,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tog_o <= 1'b0;
    else if (prog_start_i)       tog_o <= 1'b0;  // start wins over read end
    else if (busy_i && rd_end_i) tog_o <= ~tog_o;
  end

  assert_clear_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_i |=> !tog_o);
  assert_flip_on_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_end_i && !prog_start_i) |=> (tog_o != $past(tog_o)));
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !prog_start_i) |=> $stable(tog_o));
endmodule

// File: rtl/poll_status_read.sv
module poll_status_read
  import psr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              busy_i,
  input  logic              prog_start_i,
  input  logic              wr_strobe_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic              rd_act, rd_end, tog;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;
  logic              hit;
  logic [DATA_W-1:0] poll_word;
  rd_mode_e          mode;

  psr_bus_ctl u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .rd_act_o(rd_act), .rd_end_o(rd_end)
  );

  psr_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_strobe_i(wr_strobe_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .last_addr_o(last_addr), .last_data_o(last_data)
  );

  psr_toggle u_tog (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .busy_i(busy_i), .prog_start_i(prog_start_i), .rd_end_i(rd_end),
    .tog_o(tog)
  );

  assign hit = (addr_i == last_addr);

  for (genvar i = 0; i < DATA_W; i++) begin : g_poll
    if (i == POLL_BIT) begin : g_b7
      assign poll_word[i] = hit ? ~last_data[i] : arr_data_i[i];
    end else if (i == TOG_BIT) begin : g_b6
      assign poll_word[i] = tog;
    end else begin : g_lo
      assign poll_word[i] = hit ? last_data[i] : arr_data_i[i];
    end
  end

  always_comb begin
    if (!rd_act)     mode = RD_OFF;
    else if (busy_i) mode = RD_POLL;
    else             mode = RD_TRUE;
  end

  always_comb begin
    unique case (mode)
      RD_TRUE: data_o = arr_data_i;
      RD_POLL: data_o = poll_word;
      default: data_o = '0;
    endcase
  end

  assign data_oe_o = (mode != RD_OFF);

  assert_oe_qual_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && !oe_ni && we_ni));
  assert_off_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));
  assert_idle_true_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !busy_i) |-> (data_o == arr_data_i));
  assert_poll_inv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && busy_i && addr_i == last_addr) |-> (data_o[POLL_BIT] != last_data[POLL_BIT]));
  assert_poll_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && busy_i && addr_i != last_addr) |-> (data_o[POLL_BIT] == arr_data_i[POLL_BIT]));
endmodule

// File: tb/tb_poll_status_read.sv
module tb_poll_status_read;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ce_n, oe_n, we_n, busy, ps, ws;
  logic [AW-1:0] addr, wa;
  logic [DW-1:0] wd, arr, data;
  logic data_oe;

  int checks = 0, failures = 0;

  function automatic logic [DW-1:0] arr_of(logic [AW-1:0] a);
    return 8'(a * 8'd37) ^ 8'h5A;
  endfunction
  assign arr = arr_of(addr);

  poll_status_read #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .arr_data_i(arr), .busy_i(busy), .prog_start_i(ps),
    .wr_strobe_i(ws), .wr_addr_i(wa), .wr_data_i(wd),
    .data_o(data), .data_oe_o(data_oe)
  );

  // behavioural reference state
  bit m_rd, m_tog;
  logic [AW-1:0] m_la;
  logic [DW-1:0] m_ld;

  always @(posedge clk) begin
    bit ra;
    if (!rst_n) begin
      m_rd = 0; m_tog = 0; m_la = '0; m_ld = '0;
    end else begin
      ra = !ce_n && !oe_n && we_n;
      if (ps) m_tog = 0;
      else if (busy && m_rd && !ra) m_tog = !m_tog;
      m_rd = ra;
      if (ws) begin m_la = wa; m_ld = wd; end
    end
  end

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit eo, hit;
    logic [DW-1:0] ed;
    eo  = !ce_n && !oe_n && we_n;
    hit = (addr == m_la);
    chk(data_oe === eo, "R1", {7'b0, data_oe}, {7'b0, eo});
    if (!eo) chk(data === 8'h00, "R2", data, 8'h00);
    else if (!busy) chk(data === arr, "R3/R8", data, arr);
    else begin
      ed = hit ? m_ld : arr;
      ed[7] = hit ? ~m_ld[7] : arr[7];
      ed[6] = m_tog;
      if (hit) chk({data[7], data[5:0]} === {ed[7], ed[5:0]}, "R4", data, ed);
      else     chk({data[7], data[5:0]} === {ed[7], ed[5:0]}, "R5", data, ed);
      chk(data[6] === ed[6], "R6", data, ed);
    end
  endtask

  // compare at the falling edge, then apply the next cycle's inputs
  task automatic cyc(bit c, bit o, bit w, logic [AW-1:0] a, bit b, bit p,
                     bit s = 0, logic [AW-1:0] sa = '0, logic [DW-1:0] sd = '0);
    @(negedge clk);
    compare();
    ce_n = c; oe_n = o; we_n = w; addr = a; busy = b; ps = p;
    ws = s; wa = sa; wd = sd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned x;
    bit bz;
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; busy = 0; ps = 0;
    ws = 0; wa = '0; wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state seen through a busy read of address 0
    cyc(0, 0, 1, 8'h00, 1, 0);
    @(negedge clk);
    chk(data === 8'h80, "R10", data, 8'h80);
    cyc(1, 1, 1, 8'h00, 0, 0);
    // R3: idle reads; R2/R1 with each enable released
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 8'(i * 41), 0, 0);
    cyc(1, 0, 1, 8'h10, 0, 0);
    cyc(0, 1, 1, 8'h10, 0, 0);
    cyc(0, 0, 0, 8'h10, 0, 0);
    // R9: byte loads, then a programming period
    cyc(1, 1, 1, 8'h00, 0, 0, 1, 8'h12, 8'hA5);
    cyc(1, 1, 1, 8'h00, 0, 0, 1, 8'h13, 8'h3C);
    cyc(1, 1, 1, 8'h00, 1, 1);
    // R4/R6: repeated poll reads of the last byte, separated by gaps
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 1, 8'h13, 1, 0);
      cyc(0, 0, 1, 8'h13, 1, 0);
      cyc(1, 1, 1, 8'h13, 1, 0);
    end
    // R5: poll reads of another address, ended through oe then ce
    cyc(0, 0, 1, 8'h12, 1, 0);
    cyc(0, 1, 1, 8'h12, 1, 0);
    cyc(0, 0, 1, 8'h40, 1, 0);
    cyc(1, 0, 1, 8'h40, 1, 0);
    // R7: toggle at 0, then a read ends in the cycle of a programming start
    cyc(1, 1, 1, 8'h13, 1, 1);
    cyc(0, 0, 1, 8'h13, 1, 0);
    cyc(1, 1, 1, 8'h13, 1, 1);
    cyc(0, 0, 1, 8'h13, 1, 0);
    @(negedge clk);
    chk(data[6] === 1'b0, "R7", data, {data[7], 1'b0, data[5:0]});
    // R8: busy drops in the middle of a read
    cyc(0, 0, 1, 8'h13, 0, 0);
    cyc(1, 1, 1, 8'h13, 0, 0);
    cyc(0, 0, 1, 8'h13, 0, 0);
    cyc(1, 1, 1, 8'h13, 0, 0);
    // R9: a blocked write still starts a period and is polled
    cyc(1, 1, 1, 8'h00, 0, 0, 1, 8'h77, 8'hF0);
    cyc(1, 1, 1, 8'h00, 1, 1);
    cyc(0, 0, 1, 8'h77, 1, 0);
    @(negedge clk);
    chk(data === 8'h30, "R9", data, 8'h30);
    cyc(1, 1, 1, 8'h77, 1, 0);
    // mixed random traffic
    x = 32'h1234_5678;
    bz = 0;
    for (int i = 0; i < 3000; i++) begin
      bit p;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      p = (x[31:28] == 4'h0);
      if (p) bz = 1;
      else if (x[27:24] == 4'h0) bz = 0;
      cyc(x[0] & x[1], x[2] & x[3], !(x[4] & x[5] & x[6]), {5'b0, x[9:7]} + 8'h10,
          bz, p, x[12:10] == 3'b0, {5'b0, x[15:13]} + 8'h10, x[23:16]);
    end
    @(negedge clk);
    compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule